// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects 32 external interrupt lines, each synchronous to the block clock, and turns them into six core interrupt pin outputs plus a vector number. Software configures every source through a simple 32-bit register bus. Each source has an active polarity and a trigger type, either level or edge. An edge source can also be told to latch on both transitions. Each source also has an enable bit in a mask and a route that names the core pin it drives.

Level sources are pending for as long as their input, corrected for polarity, is asserted. Edge sources keep a latch that is set by the chosen transition and stays set until software clears it. Software clears the latch, or sets it to inject an event, with a single command word. A core pin output is asserted while any enabled, pending source is routed to it. The vector output names the highest-numbered active pin, counting from one.

The bus takes one access per cycle. A write is captured at the clock edge on which `bus_wr` is high. Read data is a combinational function of the word address and the current state. The bus has no handshake and no back-pressure. Core pin and vector outputs are combinational from the register state and the live inputs.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, the polarity, trigger, dual-edge, mask, route and edge-latch state are all zero. `core_pin` and `vec_num` read 0, and every readable word reads 0 while all inputs are low.
- R2: The polarity, trigger and dual-edge words are at byte offsets 0x100, 0x180 and 0x200, with bit i belonging to source i. They read back what was written. The route word for source i is at 0x500 + 4*i. Its bit 31 is the route enable and bits 5:0 are the pin number. Every other bit of a route word reads 0.
- R3: A source whose trigger bit is 0 (level) is pending exactly while its input XOR its polarity bit is 1, in the same cycle.
- R4: Writing to 0x380 enables each source whose data bit is 1. Writing to 0x300 disables each source whose data bit is 1. Zero data bits leave the mask unchanged. The mask reads at 0x400, where 1 means enabled.
- R5: A source whose trigger bit is 1 (edge) latches a pending event on a rising input when its polarity is 0, and on a falling input when its polarity is 1. With its dual-edge bit set, either transition latches. The event is visible from the cycle after the clock edge that sees the transition, and it is held until it is cleared by command.
- R6: A write to 0x280 selects the source with data bits 4:0. If data bit 31 is 1 the command sets that source's edge latch; if it is 0 the command clears it. A hardware edge event in the same cycle as a clear wins.
- R7: Core pin p (0 to 5) is asserted when at least one source is pending, enabled and route-enabled, with route pin number p. A route pin number above 5 drives no output.
- R8: `vec_num` equals the highest asserted pin number plus one, and 0 when no pin is asserted.
- R9: The pending word reads at 0x480. The command words, the mask-set and mask-clear words, and unmapped offsets read 0. Writes to the mask and pending words change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Interrupt source inputs, synchronous to clk |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_waddr | input | 10 | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_waddr, combinational |
| core_pin | output | 6 | Core interrupt pin outputs |
| vec_num | output | 3 | Highest active pin plus one, 0 when idle |

## Verification
The hardest case to reach from the ports is a hardware edge that arrives in the same clock cycle as a software clear for the same source. The latch must stay set, so the two orderings of set and clear can be told apart. The bench drives the input transition and the clear command in one bus cycle on purpose. It then adds a long random phase that mixes configuration writes, commands and input toggles, so that polarity or trigger changes also land on edges. A reference model in the bench updates on every edge and is compared on every cycle. This catches any case where the design orders these events differently.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int REG_W        = 32;
  localparam int WADDR_W      = 10;
  localparam int PIN_SEL_W    = 6;
  localparam int ROUTE_EN_BIT = 31;
  localparam int CMD_SET_BIT  = 31;

  // word addresses (byte offset >> 2)
  localparam logic [WADDR_W-1:0] WA_POL      = 10'h040;
  localparam logic [WADDR_W-1:0] WA_TRIG     = 10'h060;
  localparam logic [WADDR_W-1:0] WA_DUAL     = 10'h080;
  localparam logic [WADDR_W-1:0] WA_EDGE_CMD = 10'h0A0;
  localparam logic [WADDR_W-1:0] WA_MASK_CLR = 10'h0C0;
  localparam logic [WADDR_W-1:0] WA_MASK_SET = 10'h0E0;
  localparam logic [WADDR_W-1:0] WA_MASK     = 10'h100;
  localparam logic [WADDR_W-1:0] WA_PEND     = 10'h120;
  localparam logic [WADDR_W-1:0] WA_ROUTE    = 10'h140;

  typedef struct packed {
    logic                 en;
    logic [PIN_SEL_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [REG_W-1:0]   wdata,
  output logic [NUM_SRC-1:0] pol_q,
  output logic [NUM_SRC-1:0] trig_q,
  output logic [NUM_SRC-1:0] dual_q,
  output logic [NUM_SRC-1:0] mask_q,
  output route_t             route_q [NUM_SRC],
  output logic               cmd_valid,
  output logic               cmd_set,
  output logic [IDX_W-1:0]   cmd_idx
);
  logic [NUM_SRC-1:0] wbits;
  assign wbits = wdata[NUM_SRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (waddr == WA_POL)      pol_q  <= wbits;
      if (waddr == WA_TRIG)     trig_q <= wbits;
      if (waddr == WA_DUAL)     dual_q <= wbits;
      if (waddr == WA_MASK_SET) mask_q <= mask_q | wbits;
      if (waddr == WA_MASK_CLR) mask_q <= mask_q & ~wbits;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
    localparam logic [WADDR_W-1:0] MY_WA = WA_ROUTE + WADDR_W'(i);
    route_t r_q;
    always_ff @(posedge clk) begin
      if (!rst_n) r_q <= '0;
      else if (wr_en && waddr == MY_WA)
        r_q <= '{en: wdata[ROUTE_EN_BIT], pin: wdata[PIN_SEL_W-1:0]};
    end
    assign route_q[i] = r_q;
  end

  assign cmd_valid = wr_en && (waddr == WA_EDGE_CMD);
  assign cmd_set   = wdata[CMD_SET_BIT];
  assign cmd_idx   = wdata[IDX_W-1:0];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] trig,
  input  logic [NUM_SRC-1:0] dual,
  input  logic               cmd_valid,
  input  logic               cmd_set,
  input  logic [IDX_W-1:0]   cmd_idx,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic prev_q, latch_q, rise, fall, evt, hit;
    assign rise = irq_in[i] & ~prev_q;
    assign fall = ~irq_in[i] & prev_q;
    assign evt  = trig[i] & (dual[i] ? (rise | fall) : (pol[i] ? fall : rise));
    assign hit  = cmd_valid && (cmd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        // hardware event outranks a same-cycle clear
        if (evt)      latch_q <= 1'b1;
        else if (hit) latch_q <= cmd_set;
      end
    end

    assign pend[i] = trig[i] ? latch_q : (irq_in[i] ^ pol[i]);
  end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 6,
  parameter int VEC_W    = $clog2(NUM_PINS + 1)
) (
  input  logic [NUM_SRC-1:0]  pend,
  input  logic [NUM_SRC-1:0]  mask,
  input  route_t              route [NUM_SRC],
  output logic [NUM_PINS-1:0] core_pin,
  output logic [VEC_W-1:0]    vec_num
);
  logic [NUM_SRC-1:0] live;
  assign live = pend & mask;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      core_pin[p] = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
        if (live[i] && route[i].en && route[i].pin == PIN_SEL_W'(p))
          core_pin[p] = 1'b1;
    end
  end

  always_comb begin
    vec_num = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (core_pin[p]) vec_num = VEC_W'(p + 1);
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 6,
  parameter int VEC_W    = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                bus_wr,
  input  logic [WADDR_W-1:0]  bus_waddr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic [NUM_PINS-1:0] core_pin,
  output logic [VEC_W-1:0]    vec_num
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, mask_q, pend_w;
  route_t             route_q [NUM_SRC];
  logic               cmd_valid, cmd_set;
  logic [IDX_W-1:0]   cmd_idx;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .waddr(bus_waddr),
    .wdata(bus_wdata), .pol_q(pol_q), .trig_q(trig_q), .dual_q(dual_q),
    .mask_q(mask_q), .route_q(route_q), .cmd_valid(cmd_valid),
    .cmd_set(cmd_set), .cmd_idx(cmd_idx)
  );

  irq_edge_latch #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol(pol_q), .trig(trig_q),
    .dual(dual_q), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_idx(cmd_idx), .pend(pend_w)
  );

  irq_pin_router #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_route (
    .pend(pend_w), .mask(mask_q), .route(route_q),
    .core_pin(core_pin), .vec_num(vec_num)
  );

  logic [WADDR_W-1:0] ridx;
  route_t             route_rd;
  assign ridx     = bus_waddr - WA_ROUTE;
  assign route_rd = route_q[ridx[IDX_W-1:0]];

  always_comb begin
    bus_rdata = '0;
    case (bus_waddr)
      WA_POL:  bus_rdata[NUM_SRC-1:0] = pol_q;
      WA_TRIG: bus_rdata[NUM_SRC-1:0] = trig_q;
      WA_DUAL: bus_rdata[NUM_SRC-1:0] = dual_q;
      WA_MASK: bus_rdata[NUM_SRC-1:0] = mask_q;
      WA_PEND: bus_rdata[NUM_SRC-1:0] = pend_w;
      default: begin
        if (bus_waddr >= WA_ROUTE && ridx < WADDR_W'(NUM_SRC)) begin
          bus_rdata[ROUTE_EN_BIT]    = route_rd.en;
          bus_rdata[PIN_SEL_W-1:0]   = route_rd.pin;
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 6,
  parameter int VEC_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [WADDR_W-1:0]  bus_waddr,
  input logic [REG_W-1:0]    bus_wdata,
  input logic [NUM_PINS-1:0] core_pin,
  input logic [VEC_W-1:0]    vec_num,
  input logic [NUM_SRC-1:0]  mask_q,
  input logic [NUM_SRC-1:0]  trig_q,
  input logic [NUM_SRC-1:0]  pend_w
);
  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == WA_MASK_SET)
      |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == WA_MASK_CLR)
      |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((pend_w & $past(pend_w & trig_q)) == $past(pend_w & trig_q)));

  p_pin_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (core_pin == '0));

  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pin == '0) |-> (vec_num == '0));

  p_vec_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pin != '0) |-> (vec_num != '0 && core_pin[vec_num - 1'b1]
                          && (core_pin >> vec_num) == '0));
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
  .bus_wdata(bus_wdata), .core_pin(core_pin), .vec_num(vec_num),
  .mask_q(mask_q), .trig_q(trig_q), .pend_w(pend_w)
);

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  core_pin;
  logic [2:0]  vec_num;

  always #2 clk = ~clk;  // 250 MHz

  irq_src_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_pin(core_pin), .vec_num(vec_num)
  );

  localparam int A_POL = 'h100, A_TRIG = 'h180, A_DUAL = 'h200, A_CMD = 'h280;
  localparam int A_MCLR = 'h300, A_MSET = 'h380, A_MASK = 'h400, A_PEND = 'h480;
  localparam int A_ROUTE = 'h500;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;
  string cur_tag = "R1";
  logic [31:0] cur_irq = '0;

  // reference model state
  bit [31:0] m_pol, m_trig, m_dual, m_mask, m_latch, m_prev;
  bit        m_ren [32];
  int        m_rpin [32];

  function automatic bit [31:0] m_pend(input bit [31:0] irq);
    bit [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = m_trig[i] ? m_latch[i] : (irq[i] ^ m_pol[i]);
    return r;
  endfunction

  function automatic bit [5:0] m_pins(input bit [31:0] irq);
    bit [5:0] r = '0;
    bit [31:0] pe = m_pend(irq);
    for (int i = 0; i < 32; i++)
      if (pe[i] && m_mask[i] && m_ren[i] && m_rpin[i] < 6) r[m_rpin[i]] = 1'b1;
    return r;
  endfunction

  function automatic int m_vec(input bit [5:0] pins);
    for (int p = 5; p >= 0; p--) if (pins[p]) return p + 1;
    return 0;
  endfunction

  function automatic bit [31:0] m_read(input int a, input bit [31:0] irq);
    if (a == A_POL)  return m_pol;
    if (a == A_TRIG) return m_trig;
    if (a == A_DUAL) return m_dual;
    if (a == A_MASK) return m_mask;
    if (a == A_PEND) return m_pend(irq);
    if (a >= A_ROUTE && a < A_ROUTE + 128) begin
      int i = (a - A_ROUTE) / 4;
      return {m_ren[i], 25'd0, 6'(m_rpin[i])};
    end
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_pol = '0; m_trig = '0; m_dual = '0; m_mask = '0; m_latch = '0; m_prev = '0;
    for (int i = 0; i < 32; i++) begin m_ren[i] = 0; m_rpin[i] = 0; end
  endtask

  task automatic m_update(input bit wr, input int a, input bit [31:0] d, input bit [31:0] irq);
    bit [31:0] nl = m_latch;
    if (wr && a == A_CMD) nl[d[4:0]] = d[31];
    for (int i = 0; i < 32; i++) begin
      bit r = irq[i] && !m_prev[i];
      bit f = !irq[i] && m_prev[i];
      bit e = m_dual[i] ? (r || f) : (m_pol[i] ? f : r);
      if (m_trig[i] && e) nl[i] = 1'b1;
    end
    m_latch = nl;
    m_prev = irq;
    if (wr) begin
      if (a == A_POL)  m_pol = d;
      if (a == A_TRIG) m_trig = d;
      if (a == A_DUAL) m_dual = d;
      if (a == A_MSET) m_mask = m_mask | d;
      if (a == A_MCLR) m_mask = m_mask & ~d;
      if (a >= A_ROUTE && a < A_ROUTE + 128) begin
        m_ren[(a - A_ROUTE) / 4] = d[31];
        m_rpin[(a - A_ROUTE) / 4] = int'(d[5:0]);
      end
    end
  endtask

  // one bus cycle: drive, compare, clock, update model
  task automatic step(input bit wr, input int a, input bit [31:0] d);
    bit [5:0] ep;
    bus_wr = wr; bus_waddr = 10'(a >> 2); bus_wdata = d; irq_in = cur_irq;
    #1;
    ep = m_pins(cur_irq);
    check(core_pin == ep, "R7", "core_pin", core_pin, ep);
    check(int'(vec_num) == m_vec(ep), "R8", "vec_num", vec_num, m_vec(ep));
    check(bus_rdata == m_read(a, cur_irq), cur_tag, $sformatf("rdata@%0h", a),
          bus_rdata, m_read(a, cur_irq));
    @(posedge clk);
    if (rst_n) m_update(wr, a, d, cur_irq);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input bit [31:0] d); step(1'b1, a, d); endtask
  task automatic rd(input int a); step(1'b0, a, 32'd0); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_reset();
    @(negedge clk);
    // R1: reset state
    cur_tag = "R1";
    rd(A_POL); rd(A_MASK);
    rst_n = 1'b1;
    rd(A_POL); rd(A_TRIG); rd(A_DUAL); rd(A_MASK); rd(A_PEND);
    rd(A_ROUTE); rd(A_ROUTE + 124);

    // R2: configuration read-back
    cur_tag = "R2";
    wr(A_POL, 32'h0000_00F0); rd(A_POL);
    wr(A_TRIG, 32'hFFFF_0000); rd(A_TRIG);
    wr(A_DUAL, 32'h0F00_0000); rd(A_DUAL);
    for (int i = 0; i < 32; i++) begin
      bit en = (i != 3);
      int pin = (i % 8 == 7) ? 7 : i % 6;
      wr(A_ROUTE + 4 * i, {en, 31'h1234_5600} | 32'(pin));
    end
    for (int i = 0; i < 32; i++) rd(A_ROUTE + 4 * i);

    // R4: mask set and clear
    cur_tag = "R4";
    wr(A_MSET, 32'hFFFF_FFFF); rd(A_MASK);
    wr(A_MCLR, 32'h0000_00FF); rd(A_MASK);
    wr(A_MCLR, 32'h0000_0000); rd(A_MASK);
    wr(A_MSET, 32'h0000_0011); rd(A_MASK);
    wr(A_MSET, 32'hFFFF_FFFF);

    // R3: level sources (low half), polarity mixed
    cur_tag = "R3";
    for (int k = 0; k < 24; k++) begin
      cur_irq = {16'h0000, 16'($urandom)};
      rd(A_PEND);
    end
    cur_irq = 32'h0000_00F0; rd(A_PEND);  // all level inactive
    cur_irq = 32'h0000_0008; rd(A_PEND);  // source 3 route disabled

    // R5: edge sources (upper half)
    cur_tag = "R5";
    cur_irq = 32'h0001_0000; rd(A_PEND); rd(A_PEND);   // rise on 16
    cur_irq = 32'h0000_0000; rd(A_PEND); rd(A_PEND);   // fall: still held
    cur_irq = 32'h0100_0000; rd(A_PEND);                // rise on dual 24
    wr(A_CMD, 32'd24); rd(A_PEND);
    cur_irq = 32'h0000_0000; rd(A_PEND); rd(A_PEND);   // fall on dual 24
    wr(A_POL, 32'h0010_00F0);                           // 20 falling-active
    cur_irq = 32'h0010_0000; rd(A_PEND);                // rise: no event
    cur_irq = 32'h0000_0000; rd(A_PEND); rd(A_PEND);   // fall: event
    cur_irq = 32'h0080_0000; rd(A_PEND);                // source 23 pin 7
    rd(A_PEND);

    // R6: edge command set, clear, and collision
    cur_tag = "R6";
    for (int i = 16; i < 32; i++) wr(A_CMD, 32'(i));
    rd(A_PEND);
    wr(A_CMD, 32'h8000_0011); rd(A_PEND);
    wr(A_CMD, 32'h8000_001D); rd(A_PEND);
    wr(A_CMD, 32'h0000_0011); rd(A_PEND);
    cur_irq = 32'h0004_0000;                            // rise on 18 ...
    wr(A_CMD, 32'h0000_0012);                           // ... with clear of 18
    rd(A_PEND); rd(A_PEND);
    wr(A_CMD, 32'h0000_0012); rd(A_PEND);

    // R9: read-only and unmapped words
    cur_tag = "R9";
    rd(32'h000); rd(32'h7FC); rd(A_CMD); rd(A_MCLR); rd(A_MSET); rd(A_ROUTE + 128);
    wr(A_MASK, 32'h0000_0000); rd(A_MASK);
    wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND);

    // random mix covering all behaviour (R7 / R8 checked every cycle)
    cur_tag = "R7";
    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom_range(0, 11);
      int a;
      bit [31:0] d = $urandom;
      if ($urandom_range(0, 2) == 0) cur_irq = cur_irq ^ (32'd1 << $urandom_range(0, 31));
      case (sel)
        0: a = A_POL;  1: a = A_TRIG; 2: a = A_DUAL; 3: a = A_CMD;
        4: a = A_MCLR; 5: a = A_MSET; 6: a = A_MASK; 7: a = A_PEND;
        default: a = A_ROUTE + 4 * $urandom_range(0, 31);
      endcase
      if (sel == 4 || sel == 5) d = d & $urandom;
      if ($urandom_range(0, 3) == 0) wr(a, d); else rd(a);
    end

    finish_run();
  end
endmodule